// File: doc/BRIEF.md
# Duplicate-Tag Coherence Snoop Filter

This block sits beside up to four processor data caches. It holds a private copy of every cache's line tags and MESI states. Each cycle it can take one request from one processor. For a coherent request it looks up the copies of all the other processors. Only those processors that really hold the line receive a snoop. The block then decides whether the requester's data comes from a remote cache (cache-to-cache intervention) or from the shared memory port.

The block also writes the new states back into its tag copies. It does this at the same clock edge, so the next request already sees the result. Instruction fetches go straight to memory with no snoop. So does all traffic from a processor that is marked as not taking part in coherence. The tag copies are direct-mapped, one entry per set per processor. An address splits into a line offset (`LINE_W` bits), a set index (`SET_W` bits) and a tag (the remaining upper bits).

Top module: `sfc_filter`

## Requirements
- R1: After reset every tag-copy entry is Invalid, and `snp_cmd`, `mem_valid` and `rsp_valid` are all 0.
- R2: The results of a request sampled at one rising edge appear on the outputs after that edge and last one cycle only. A cycle with `req_valid` low gives all-zero `snp_cmd`, `mem_valid` 0 and `rsp_valid` 0. A tag update is visible to a request in the very next cycle.
- R3: A coherent read miss (`req_op` 0) that no other coherent processor holds gives a memory read (`mem_valid` 1, `mem_write` 0) at the request address. The requester receives Exclusive. States are encoded Invalid 0, Shared 1, Exclusive 2, Modified 3.
- R4: A coherent read miss that other processors hold is served by intervention from the lowest-numbered holder. That holder alone gets command 2 (share). `rsp_remote` is 1 and `rsp_src` names the holder. The holder and the requester both end in Shared. If the holder was Modified, a memory write-back at the request address is issued in the same cycle; otherwise there is no memory request.
- R5: A coherent write or upgrade (`req_op` 1) leaves the requester Modified and every other holder Invalid. If the requester did not hold the line and holders exist, the lowest holder gets command 3 (supply and invalidate) and the others get command 1 (invalidate), with `rsp_remote` 1. If the requester already held the line, all holders get command 1, and there is no data transfer and no memory request. With no line and no holders, a memory read is issued.
- R6: An eviction (`req_op` 2) of a line the requester holds clears its entry. A Modified line also gives a memory write at the request address. Eviction of a line not held changes nothing. An eviction never snoops, and the reported state is Invalid.
- R7: A line-fill update (`req_op` 3) writes `req_state` into the requester's entry for that address. It gives no snoop and no memory request, and the reported state is `req_state`.
- R8: An instruction fetch (`req_op` 4) from any processor gives a memory read only. There is no snoop, no tag change, reported state Invalid and `rsp_remote` 0.
- R9: A processor whose `coh_en` bit is 0 makes no snoops and no tag changes. Its reads go to memory as reads, its writes and evictions as memory writes, and its updates do nothing. Its entries are never counted as holders.
- R10: Snoop commands (2 bits per processor at `snp_cmd[2c+1:2c]`) go only to holders, never to the requester. At most one processor is told to supply data. Each snoop occupies the target for a single cycle.
- R11: An entry whose tag differs from the request's tag in the same set is not a holder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coh_en | input | NCPU | Per-processor coherence participation |
| req_valid | input | 1 | Request present this cycle |
| req_cpu | input | CPU_W | Requesting processor |
| req_op | input | 3 | 0 read miss, 1 write/upgrade, 2 evict, 3 update, 4 instruction fetch |
| req_addr | input | ADDR_W | Request byte address |
| req_state | input | 2 | State written by an update request |
| snp_cmd | output | 2*NCPU | Per-processor snoop command: 0 none, 1 invalidate, 2 share, 3 supply-and-invalidate |
| mem_valid | output | 1 | Memory request present |
| mem_write | output | 1 | Memory request is a write (else read) |
| out_addr | output | ADDR_W | Address of the snoop and memory request |
| rsp_valid | output | 1 | Outcome of the previous cycle's request |
| rsp_cpu | output | CPU_W | Processor the outcome belongs to |
| rsp_state | output | 2 | Requester's new state |
| rsp_remote | output | 1 | Data is supplied by a remote cache |
| rsp_src | output | CPU_W | Supplying processor when `rsp_remote` is 1, else 0 |

## Verification
Every result of a request (snoop commands, memory request, response fields and address) is due exactly one cycle after the rising edge that samples it. The tag copies change at that same edge, so a request in the following cycle already sees them. The bench drives each request at a falling edge and keeps a behavioural tag model that it updates when the request is issued. It compares every output at the next falling edge, including the all-quiet outputs expected after idle cycles. Back-to-back random requests then exercise the case where the state a request reads was written by the request just before it.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [2:0] {
        OP_RD     = 3'd0,
        OP_WR     = 3'd1,
        OP_EVICT  = 3'd2,
        OP_UPD    = 3'd3,
        OP_IFETCH = 3'd4
    } op_t;

    typedef enum logic [1:0] {
        SN_NONE  = 2'd0,
        SN_INV   = 2'd1,
        SN_SHARE = 2'd2,
        SN_TAKE  = 2'd3
    } snp_t;

    typedef struct packed {
        logic valid;
        logic write;
    } mreq_t;

    function automatic logic is_held(input mesi_t s);
        return s != ST_I;
    endfunction

    function automatic mreq_t mem_rd();
        mreq_t m;
        m.valid = 1'b1;
        m.write = 1'b0;
        return m;
    endfunction

    function automatic mreq_t mem_wr();
        mreq_t m;
        m.valid = 1'b1;
        m.write = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sfc_dup_tags.sv
module sfc_dup_tags
    import sfc_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic [TAG_W-1:0] rd_tag,
    output mesi_t            rd_state,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  mesi_t            wr_state
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q [SETS];
    mesi_t            st_q  [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) begin
                st_q[i] <= ST_I;
            end
        end else if (wr_en) begin
            st_q[wr_set] <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set] <= wr_tag;
        end
    end

    assign rd_tag   = tag_q[rd_set];
    assign rd_state = st_q[rd_set];

endmodule

// File: rtl/sfc_policy.sv
module sfc_policy
    import sfc_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic             req_valid,
    input  logic [CPU_W-1:0] req_cpu,
    input  logic [2:0]       req_op,
    input  mesi_t            req_state,
    input  logic [NCPU-1:0]  coh_en,
    input  mesi_t            hit_st   [NCPU],
    output logic [NCPU-1:0]  wr_en,
    output mesi_t            wr_state [NCPU],
    output snp_t             snp      [NCPU],
    output mreq_t            mem,
    output mesi_t            grant,
    output logic             remote,
    output logic [CPU_W-1:0] src
);
    mesi_t           own;
    logic            own_coh;
    logic [NCPU-1:0] holders;
    logic            any_h;
    logic            req_wr;

    // Own line state, coherence flag and the set of remote holders.
    always_comb begin
        own     = ST_I;
        own_coh = 1'b0;
        holders = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (CPU_W'(c) == req_cpu) begin
                own     = hit_st[c];
                own_coh = coh_en[c];
            end else if (coh_en[c] && is_held(hit_st[c])) begin
                holders[c] = 1'b1;
            end
        end
        src = '0;
        for (int c = NCPU - 1; c >= 0; c--) begin
            if (holders[c]) begin
                src = CPU_W'(c);
            end
        end
        any_h = |holders;
    end

    always_comb begin
        wr_en  = '0;
        mem    = '0;
        grant  = ST_I;
        remote = 1'b0;
        req_wr = 1'b0;
        for (int c = 0; c < NCPU; c++) begin
            wr_state[c] = ST_I;
            snp[c]      = SN_NONE;
        end

        if (req_valid) begin
            if (req_op == OP_IFETCH) begin
                mem = mem_rd();
            end else if (!own_coh) begin
                case (req_op)
                    OP_RD:             mem = mem_rd();
                    OP_WR, OP_EVICT:   mem = mem_wr();
                    default:           mem = '0;
                endcase
            end else begin
                case (req_op)
                    OP_RD: begin
                        req_wr = 1'b1;
                        if (any_h) begin
                            snp[src]      = SN_SHARE;
                            wr_en[src]    = 1'b1;
                            wr_state[src] = ST_S;
                            if (hit_st[src] == ST_M) begin
                                mem = mem_wr();
                            end
                            remote = 1'b1;
                            grant  = ST_S;
                        end else begin
                            mem   = mem_rd();
                            grant = ST_E;
                        end
                    end
                    OP_WR: begin
                        req_wr = 1'b1;
                        grant  = ST_M;
                        for (int c = 0; c < NCPU; c++) begin
                            if (holders[c]) begin
                                snp[c]      = SN_INV;
                                wr_en[c]    = 1'b1;
                                wr_state[c] = ST_I;
                            end
                        end
                        if (own == ST_I) begin
                            if (any_h) begin
                                snp[src] = SN_TAKE;
                                remote   = 1'b1;
                            end else begin
                                mem = mem_rd();
                            end
                        end
                    end
                    OP_EVICT: begin
                        if (is_held(own)) begin
                            req_wr = 1'b1;
                            if (own == ST_M) begin
                                mem = mem_wr();
                            end
                        end
                    end
                    OP_UPD: begin
                        req_wr = 1'b1;
                        grant  = req_state;
                    end
                    default: req_wr = 1'b0;
                endcase
            end
        end

        for (int c = 0; c < NCPU; c++) begin
            if (req_wr && CPU_W'(c) == req_cpu) begin
                wr_en[c]    = 1'b1;
                wr_state[c] = grant;
            end
        end
    end

endmodule

// File: rtl/sfc_filter.sv
module sfc_filter
    import sfc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 32,
    parameter int LINE_W = 5,
    parameter int SET_W  = 6,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCPU-1:0]     coh_en,
    input  logic                req_valid,
    input  logic [CPU_W-1:0]    req_cpu,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_state,
    output logic [2*NCPU-1:0]   snp_cmd,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   out_addr,
    output logic                rsp_valid,
    output logic [CPU_W-1:0]    rsp_cpu,
    output logic [1:0]          rsp_state,
    output logic                rsp_remote,
    output logic [CPU_W-1:0]    rsp_src
);
    localparam int TAG_W = ADDR_W - LINE_W - SET_W;

    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  bank_tag [NCPU];
    mesi_t             bank_st  [NCPU];
    mesi_t             hit_st   [NCPU];
    logic [NCPU-1:0]   wr_en;
    mesi_t             wr_state [NCPU];
    snp_t              snp      [NCPU];
    logic [2*NCPU-1:0] snp_d;
    mreq_t             mem;
    mesi_t             grant;
    logic              remote;
    logic [CPU_W-1:0]  src;

    assign req_set = req_addr[LINE_W +: SET_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        sfc_dup_tags #(
            .SET_W (SET_W),
            .TAG_W (TAG_W)
        ) u_tags (
            .clk      (clk),
            .rst      (rst),
            .rd_set   (req_set),
            .rd_tag   (bank_tag[c]),
            .rd_state (bank_st[c]),
            .wr_en    (wr_en[c]),
            .wr_set   (req_set),
            .wr_tag   (req_tag),
            .wr_state (wr_state[c])
        );

        assign hit_st[c]         = (bank_tag[c] == req_tag) ? bank_st[c] : ST_I;
        assign snp_d[2*c +: 2]   = snp[c];
    end

    sfc_policy #(
        .NCPU  (NCPU),
        .CPU_W (CPU_W)
    ) u_policy (
        .req_valid (req_valid),
        .req_cpu   (req_cpu),
        .req_op    (req_op),
        .req_state (mesi_t'(req_state)),
        .coh_en    (coh_en),
        .hit_st    (hit_st),
        .wr_en     (wr_en),
        .wr_state  (wr_state),
        .snp       (snp),
        .mem       (mem),
        .grant     (grant),
        .remote    (remote),
        .src       (src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snp_cmd    <= '0;
            mem_valid  <= 1'b0;
            mem_write  <= 1'b0;
            out_addr   <= '0;
            rsp_valid  <= 1'b0;
            rsp_cpu    <= '0;
            rsp_state  <= 2'd0;
            rsp_remote <= 1'b0;
            rsp_src    <= '0;
        end else begin
            snp_cmd    <= snp_d;
            mem_valid  <= mem.valid;
            mem_write  <= mem.write;
            rsp_valid  <= req_valid;
            rsp_cpu    <= req_cpu;
            rsp_state  <= grant;
            rsp_remote <= remote;
            rsp_src    <= remote ? src : '0;
            if (req_valid) begin
                out_addr <= req_addr;
            end
        end
    end

endmodule

// File: rtl/sfc_filter_chk.sv
module sfc_filter_chk #(
    parameter int NCPU = 4,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [NCPU-1:0]   coh_en,
    input logic              req_valid,
    input logic [CPU_W-1:0]  req_cpu,
    input logic [2:0]        req_op,
    input logic [2*NCPU-1:0] snp_cmd,
    input logic              mem_valid,
    input logic              rsp_valid,
    input logic [CPU_W-1:0]  rsp_cpu,
    input logic [1:0]        rsp_state,
    input logic              rsp_remote,
    input logic [CPU_W-1:0]  rsp_src
);
    logic [NCPU-1:0] data_src;
    logic [1:0]      self_cmd;
    logic            req_coh;

    always_comb begin
        self_cmd = 2'd0;
        req_coh  = 1'b0;
        for (int c = 0; c < NCPU; c++) begin
            data_src[c] = snp_cmd[2*c+1];
            if (CPU_W'(c) == rsp_cpu) self_cmd = snp_cmd[2*c +: 2];
            if (CPU_W'(c) == req_cpu) req_coh  = coh_en[c];
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (snp_cmd == '0 && !mem_valid && !rsp_valid));

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_valid && rsp_cpu == $past(req_cpu)));

    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (snp_cmd == '0 && !mem_valid && !rsp_valid));

    // R10
    no_self_snoop_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> self_cmd == 2'd0);

    // R10
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(data_src) <= 1);

    // R4
    remote_src_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_remote |-> data_src == (NCPU'(1) << rsp_src));

    // R3
    local_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_remote) |-> data_src == '0);

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 3'd4 || !req_coh)) |=>
            (snp_cmd == '0 && rsp_state == 2'd0 && !rsp_remote));

    // R7
    upd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd3) |=> (snp_cmd == '0 && !mem_valid));

    // R6
    evict_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd2) |=> (snp_cmd == '0 && rsp_state == 2'd0));

endmodule

bind sfc_filter sfc_filter_chk #(.NCPU(NCPU)) u_chk (.*);

// File: tb/sfc_filter_test.sv
module sfc_filter_test;
    localparam int NCPU   = 4;
    localparam int ADDR_W = 32;
    localparam int LINE_W = 5;
    localparam int SET_W  = 6;
    localparam int SETS   = 1 << SET_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCPU-1:0]   coh_en = '1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_cpu = '0;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_state = '0;
    logic [2*NCPU-1:0] snp_cmd;
    logic              mem_valid, mem_write, rsp_valid, rsp_remote;
    logic [ADDR_W-1:0] out_addr;
    logic [1:0]        rsp_cpu, rsp_state, rsp_src;

    always #10 clk = ~clk;

    sfc_filter #(.NCPU(NCPU), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .SET_W(SET_W)) uut (
        .clk(clk), .rst(rst), .coh_en(coh_en), .req_valid(req_valid), .req_cpu(req_cpu),
        .req_op(req_op), .req_addr(req_addr), .req_state(req_state), .snp_cmd(snp_cmd),
        .mem_valid(mem_valid), .mem_write(mem_write), .out_addr(out_addr),
        .rsp_valid(rsp_valid), .rsp_cpu(rsp_cpu), .rsp_state(rsp_state),
        .rsp_remote(rsp_remote), .rsp_src(rsp_src)
    );

    // Behavioural model of the tag copies.
    int mtag [NCPU][SETS];
    int mst  [NCPU][SETS];

    logic [2*NCPU-1:0] e_snp = '0;
    logic              e_mv = 0, e_mw = 0, e_rv = 0, e_rr = 0;
    logic [ADDR_W-1:0] e_addr = '0;
    int                e_rcpu = 0, e_rst = 0, e_rsrc = 0;
    string             lab = "R1";
    int                total = 0, bad = 0, cyc = 0;

    function automatic logic [ADDR_W-1:0] mk(int t, int s, int off);
        return ADDR_W'((t << (LINE_W + SET_W)) | (s << LINE_W) | off);
    endfunction

    task automatic compare();
        int errs = 0;
        total++;
        if (snp_cmd !== e_snp) begin
            errs++; $display("FAIL %s snp_cmd actual=%h expected=%h", lab, snp_cmd, e_snp);
        end
        if (mem_valid !== e_mv) begin
            errs++; $display("FAIL %s mem_valid actual=%b expected=%b", lab, mem_valid, e_mv);
        end
        if (e_mv && mem_write !== e_mw) begin
            errs++; $display("FAIL %s mem_write actual=%b expected=%b", lab, mem_write, e_mw);
        end
        if ((e_mv || e_snp != 0) && out_addr !== e_addr) begin
            errs++; $display("FAIL %s out_addr actual=%h expected=%h", lab, out_addr, e_addr);
        end
        if (rsp_valid !== e_rv) begin
            errs++; $display("FAIL %s rsp_valid actual=%b expected=%b", lab, rsp_valid, e_rv);
        end
        if (e_rv) begin
            if (int'(rsp_cpu) != e_rcpu) begin
                errs++; $display("FAIL %s rsp_cpu actual=%0d expected=%0d", lab, rsp_cpu, e_rcpu);
            end
            if (int'(rsp_state) != e_rst) begin
                errs++; $display("FAIL %s rsp_state actual=%0d expected=%0d", lab, rsp_state, e_rst);
            end
            if (rsp_remote !== e_rr) begin
                errs++; $display("FAIL %s rsp_remote actual=%b expected=%b", lab, rsp_remote, e_rr);
            end
            if (int'(rsp_src) != e_rsrc) begin
                errs++; $display("FAIL %s rsp_src actual=%0d expected=%0d", lab, rsp_src, e_rsrc);
            end
        end
        if (errs != 0) bad++;
    endtask

    task automatic clear_exp();
        e_snp = '0; e_mv = 0; e_mw = 0; e_rv = 0; e_rr = 0;
        e_rcpu = 0; e_rst = 0; e_rsrc = 0;
    endtask

    task automatic model(int cpu, int op, logic [ADDR_W-1:0] addr, int st);
        int s, t, own, src;
        logic [NCPU-1:0] hl;
        clear_exp();
        e_rv = 1; e_rcpu = cpu; e_addr = addr;
        s = int'((addr >> LINE_W) & ADDR_W'(SETS - 1));
        t = int'(addr >> (LINE_W + SET_W));
        own = (mst[cpu][s] != 0 && mtag[cpu][s] == t) ? mst[cpu][s] : 0;
        hl = '0; src = -1;
        for (int c = 0; c < NCPU; c++) begin
            if (c != cpu && coh_en[c] && mst[c][s] != 0 && mtag[c][s] == t) begin
                hl[c] = 1'b1;
                if (src < 0) src = c;
            end
        end
        if (op == 4) begin
            e_mv = 1; e_mw = 0;
        end else if (!coh_en[cpu]) begin
            if (op == 0) begin e_mv = 1; e_mw = 0; end
            if (op == 1 || op == 2) begin e_mv = 1; e_mw = 1; end
        end else begin
            case (op)
                0: begin
                    if (src >= 0) begin
                        e_snp[2*src +: 2] = 2'd2;
                        if (mst[src][s] == 3) begin e_mv = 1; e_mw = 1; end
                        mst[src][s] = 1;
                        e_rr = 1; e_rsrc = src; e_rst = 1;
                    end else begin
                        e_mv = 1; e_mw = 0; e_rst = 2;
                    end
                    mst[cpu][s] = e_rst; mtag[cpu][s] = t;
                end
                1: begin
                    for (int c = 0; c < NCPU; c++) begin
                        if (hl[c]) begin
                            e_snp[2*c +: 2] = 2'd1;
                            mst[c][s] = 0;
                        end
                    end
                    if (own == 0) begin
                        if (src >= 0) begin
                            e_snp[2*src +: 2] = 2'd3;
                            e_rr = 1; e_rsrc = src;
                        end else begin
                            e_mv = 1; e_mw = 0;
                        end
                    end
                    e_rst = 3; mst[cpu][s] = 3; mtag[cpu][s] = t;
                end
                2: begin
                    if (own != 0) begin
                        if (own == 3) begin e_mv = 1; e_mw = 1; end
                        mst[cpu][s] = 0;
                    end
                end
                3: begin
                    mst[cpu][s] = st; mtag[cpu][s] = t; e_rst = st;
                end
                default: ;
            endcase
        end
    endtask

    task automatic issue(int cpu, int op, logic [ADDR_W-1:0] addr, int st, string l);
        @(negedge clk);
        compare();
        req_valid = 1'b1; req_cpu = 2'(cpu); req_op = 3'(op);
        req_addr = addr; req_state = 2'(st);
        model(cpu, op, addr, st);
        lab = l;
    endtask

    task automatic idle(string l);
        @(negedge clk);
        compare();
        req_valid = 1'b0;
        clear_exp();
        lab = l;
    endtask

    task automatic set_coh(logic [NCPU-1:0] v, string l);
        @(negedge clk);
        compare();
        req_valid = 1'b0; coh_en = v;
        clear_exp();
        lab = l;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            bad++; total++;
            $display("FAIL R2 watchdog expired actual=%0d cycles expected=completion", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a, b, c, d, e, f;
        for (int i = 0; i < NCPU; i++)
            for (int j = 0; j < SETS; j++) begin mst[i][j] = 0; mtag[i][j] = 0; end
        a = mk(5, 3, 4);  b = mk(9, 3, 0);  c = mk(2, 63, 8);
        d = mk(7, 10, 0); e = mk(11, 20, 0); f = mk(12, 21, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R1"); idle("R1");
        issue(0, 0, a, 0, "R3");              // no holder: memory read, Exclusive
        issue(1, 0, a, 0, "R4");              // intervention from cpu0
        issue(2, 0, a, 0, "R10");             // two holders, only lowest snooped
        issue(3, 1, a, 0, "R5");              // write miss: take from 0, invalidate 1,2
        issue(1, 0, a, 0, "R4");              // Modified source: write-back too
        issue(1, 1, a, 0, "R5");              // upgrade from Shared
        idle("R2");
        issue(1, 2, a, 0, "R6");              // evict Modified
        issue(1, 2, a, 0, "R6");              // evict a line not held
        issue(2, 0, b, 0, "R11");             // same set, other tag
        issue(0, 1, c, 0, "R5");              // write with no holders
        issue(0, 1, c, 0, "R5");              // already Modified
        issue(2, 3, d, 3, "R7");              // update to Modified
        issue(3, 0, d, 0, "R7");              // update is seen by a reader
        issue(3, 4, d, 0, "R8");              // instruction fetch
        issue(0, 0, d, 0, "R8");
        issue(2, 2, b, 0, "R6");              // evict Exclusive: no memory
        set_coh(4'b1101, "R9");
        issue(1, 0, e, 0, "R9");
        issue(1, 1, e, 0, "R9");
        issue(1, 3, e, 2, "R9");
        issue(0, 0, e, 0, "R9");              // cpu1 recorded nothing
        set_coh(4'b1111, "R9");
        issue(2, 0, f, 0, "R9");
        set_coh(4'b1011, "R9");
        issue(0, 0, f, 0, "R9");              // non-coherent holder ignored
        set_coh(4'b1111, "R9");
        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 4) == 0) begin
                idle("R2");
            end else begin
                issue(int'($urandom_range(0, 3)), int'($urandom_range(0, 4)),
                      mk(int'($urandom_range(0, 2)), int'($urandom_range(0, 1)),
                         int'($urandom_range(0, 31))),
                      int'($urandom_range(0, 3)), "R2");
            end
        end
        idle("R2"); idle("R2"); idle("R2");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule